// File: doc/BRIEF.md
# Frame-Transfer Exposure Sequencer

This block runs the frame-level timing of an area image sensor that has a shielded memory zone next to its image zone. On each accepted frame request it goes through four stages in order. First is an optional obturation, or electronic shutter, interval. During it all image-zone phases are held low, so photocharge drains away through the antiblooming drain. Integration follows, with the antiblooming gate high. Next the gate is dropped and the whole frame is shifted from the image zone into the memory zone. Last, the memory zone is read out line by line.

The block drives two levels: the antiblooming gate level and the image-clear level. It does not generate the analog phases. Each vertical shift is handed to a vertical phase generator through a start/done handshake. Each readout line is handed to a horizontal readout sequencer through a second start/done handshake. While a line is being read, a 2-bit class code tells downstream logic whether that line is a dummy, dark-reference, isolation or useful video line.

States: `ST_IDLE` (waiting), `ST_OBTURATE` (shutter drain), `ST_INTEGRATE` (exposure), `ST_ABG_LEAD` (gate low, settling before the first shift), `ST_SHIFT_REQ` / `ST_SHIFT_WAIT` (one vertical shift handshake), `ST_ABG_TRAIL` (gate low, settling after the last shift), `ST_LINE_REQ` / `ST_LINE_WAIT` (one line handshake), `ST_DONE` (end-of-frame pulse).

Transitions:
- IDLE→OBTURATE on a start request with a non-zero shutter length.
- IDLE→INTEGRATE on a start request with a zero shutter length.
- OBTURATE→INTEGRATE and INTEGRATE→ABG_LEAD when the cycle timer expires.
- ABG_LEAD→SHIFT_REQ when the settling time has elapsed.
- SHIFT_REQ→SHIFT_WAIT always.
- SHIFT_WAIT→SHIFT_REQ on a shift done that is not the last one.
- SHIFT_WAIT→ABG_TRAIL on the last shift done.
- ABG_TRAIL→LINE_REQ when the settling time has elapsed.
- LINE_REQ→LINE_WAIT always.
- LINE_WAIT→LINE_REQ on a line done that is not the last one.
- LINE_WAIT→DONE on the last line done.
- DONE→IDLE always.

Top module: `ccd_frame_seq`

## Requirements
- R1: After reset and while idle, `abg_high` is 1, and `img_clear`, `vshift_start`, `line_start`, `line_active` and `frame_done` are 0. `line_class` is 2'b00.
- R2: When `start_frame` is sampled in idle with `obt_len` non-zero, `img_clear` is high for exactly `obt_len` cycles, starting the cycle after the sampling edge, and `abg_high` stays 1 during that time. With `obt_len` zero, `img_clear` never rises.
- R3: After obturation (or straight after the accepting edge when there is none), `abg_high` stays 1 with `img_clear` low for exactly `int_len` cycles. An `int_len` of zero counts as one cycle.
- R4: `abg_high` falls and stays low for exactly `GUARD_CYC` cycles before the first `vshift_start` of the frame.
- R5: Each frame issues exactly 1056 one-cycle `vshift_start` pulses. Every pulse after the first comes only after a `vshift_done` for the one before it, and `abg_high` is 0 whenever `vshift_start` is high.
- R6: After the last `vshift_done` is sampled, `abg_high` stays low for exactly `GUARD_CYC` further cycles and then returns to 1.
- R7: Each frame issues exactly 1056 one-cycle `line_start` pulses. Every pulse after the first comes only after a `line_done` for the one before it.
- R8: `line_class` codes are dummy 2'b00, dark 2'b01, isolation 2'b10 and useful 2'b11. Lines 0..1055 are classed in this order: 1 dummy, 12 dark, 3 isolation, 1024 useful, 3 isolation, 12 dark, 1 dummy.
- R9: `line_class` keeps its value for every cycle that `line_active` is high for one line, from that line's `line_start` until its `line_done`.
- R10: `frame_done` is a one-cycle pulse in the cycle after the last `line_done` is sampled, and the block is idle afterwards.
- R11: A `start_frame` that arrives while a frame is in progress is ignored. No new obturation, integration or shift follows once the current frame ends.
- R12: The shutter and integration lengths are captured when a frame is accepted. Changing `obt_len` or `int_len` afterwards does not change the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_frame | input | 1 | Request to begin a frame (used only when idle) |
| obt_len | input | OBT_W | Shutter drain length in cycles, 0 = no shutter |
| int_len | input | INT_W | Integration length in cycles |
| vshift_done | input | 1 | Vertical phase generator finished one shift |
| line_done | input | 1 | Horizontal sequencer finished one line |
| abg_high | output | 1 | Antiblooming gate level (1 = high) |
| img_clear | output | 1 | Force all image-zone phases low (drain photocharge) |
| vshift_start | output | 1 | Request one image-to-memory shift |
| line_start | output | 1 | Request readout of one memory line |
| line_active | output | 1 | A line readout is in progress |
| line_class | output | 2 | Class of the line being read |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
All outputs are decoded from the state register, so each result appears one edge after the input that causes it:
- `img_clear` or integration begins the cycle after `start_frame` is sampled.
- The next `vshift_start` or `line_start` appears the cycle after the matching done is sampled.
- `frame_done` appears one cycle after the last `line_done`.
- `abg_high` returns `GUARD_CYC + 1` cycles after the last `vshift_done`.

The bench records the cycle number at which its responders drive each done. It compares the cycle numbers of the output events against those records, plus the latencies listed above. It measures phase lengths by counting falling-edge samples of the outputs, so every comparison is made half a cycle away from the edge where the outputs change.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OBTURATE,
        ST_INTEGRATE,
        ST_ABG_LEAD,
        ST_SHIFT_REQ,
        ST_SHIFT_WAIT,
        ST_ABG_TRAIL,
        ST_LINE_REQ,
        ST_LINE_WAIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        LC_DUMMY  = 2'b00,
        LC_DARK   = 2'b01,
        LC_ISOL   = 2'b10,
        LC_USEFUL = 2'b11
    } line_class_t;

endpackage

// File: rtl/ccd_cycle_timer.sv
module ccd_cycle_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/ccd_step_counter.sv
module ccd_step_counter #(
    parameter int LIMIT = 1056,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_last
);

    localparam logic [W-1:0] LAST_IDX = W'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign at_last = (count == LAST_IDX);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_last); // R5

endmodule

// File: rtl/ccd_line_classifier.sv
module ccd_line_classifier
    import ccd_seq_pkg::*;
#(
    parameter int EDGE_LINES   = 1,
    parameter int DARK_LINES   = 12,
    parameter int ISOL_LINES   = 3,
    parameter int USEFUL_LINES = 1024,
    parameter int W            = 11
) (
    input  logic [W-1:0] idx,
    input  logic         enable,
    output line_class_t  cls
);

    localparam int B_TOP_EDGE  = EDGE_LINES;
    localparam int B_TOP_DARK  = B_TOP_EDGE + DARK_LINES;
    localparam int B_TOP_ISOL  = B_TOP_DARK + ISOL_LINES;
    localparam int B_USEFUL    = B_TOP_ISOL + USEFUL_LINES;
    localparam int B_BOT_ISOL  = B_USEFUL + ISOL_LINES;
    localparam int B_BOT_DARK  = B_BOT_ISOL + DARK_LINES;

    int unsigned n;

    always_comb begin
        n = 32'(idx);
        if (!enable) begin
            cls = LC_DUMMY;
        end else if (n < B_TOP_EDGE) begin
            cls = LC_DUMMY;
        end else if (n < B_TOP_DARK) begin
            cls = LC_DARK;
        end else if (n < B_TOP_ISOL) begin
            cls = LC_ISOL;
        end else if (n < B_USEFUL) begin
            cls = LC_USEFUL;
        end else if (n < B_BOT_ISOL) begin
            cls = LC_ISOL;
        end else if (n < B_BOT_DARK) begin
            cls = LC_DARK;
        end else begin
            cls = LC_DUMMY;
        end
    end

endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
    import ccd_seq_pkg::*;
#(
    parameter int EDGE_LINES   = 1,
    parameter int DARK_LINES   = 12,
    parameter int ISOL_LINES   = 3,
    parameter int USEFUL_LINES = 1024,
    parameter int GUARD_CYC    = 10,
    parameter int OBT_W        = 16,
    parameter int INT_W        = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_frame,
    input  logic [OBT_W-1:0] obt_len,
    input  logic [INT_W-1:0] int_len,
    input  logic             vshift_done,
    input  logic             line_done,
    output logic             abg_high,
    output logic             img_clear,
    output logic             vshift_start,
    output logic             line_start,
    output logic             line_active,
    output logic [1:0]       line_class,
    output logic             frame_done
);

    localparam int TOTAL_LINES = 2 * (EDGE_LINES + DARK_LINES + ISOL_LINES) + USEFUL_LINES;
    localparam int LINE_W      = $clog2(TOTAL_LINES);
    localparam int LEN_W       = (INT_W > OBT_W) ? INT_W : OBT_W;
    localparam int TMR_W       = ($clog2(GUARD_CYC + 1) > LEN_W) ? $clog2(GUARD_CYC + 1) : LEN_W;
    localparam logic [TMR_W-1:0] GUARD_LOAD = TMR_W'(GUARD_CYC - 1);

    seq_state_t        state, nxt;
    logic [INT_W-1:0]  int_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              cnt_clr, cnt_inc;
    logic [LINE_W-1:0] step_idx;
    logic              step_last;
    line_class_t       cls;

    function automatic logic [TMR_W-1:0] len_to_load(input logic [TMR_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

    ccd_cycle_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ccd_step_counter #(.LIMIT(TOTAL_LINES), .W(LINE_W)) u_steps (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .count   (step_idx),
        .at_last (step_last)
    );

    ccd_line_classifier #(
        .EDGE_LINES   (EDGE_LINES),
        .DARK_LINES   (DARK_LINES),
        .ISOL_LINES   (ISOL_LINES),
        .USEFUL_LINES (USEFUL_LINES),
        .W            (LINE_W)
    ) u_class (
        .idx    (step_idx),
        .enable (line_active),
        .cls    (cls)
    );

    // State register and captured integration length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            int_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start_frame) begin
                int_q <= int_len;
            end
        end
    end

    // Next state, timer and counter control
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_frame) begin
                    tmr_load = 1'b1;
                    if (obt_len != '0) begin
                        nxt     = ST_OBTURATE;
                        tmr_val = len_to_load(TMR_W'(obt_len));
                    end else begin
                        nxt     = ST_INTEGRATE;
                        tmr_val = len_to_load(TMR_W'(int_len));
                    end
                end
            end
            ST_OBTURATE: begin
                if (tmr_expired) begin
                    nxt      = ST_INTEGRATE;
                    tmr_load = 1'b1;
                    tmr_val  = len_to_load(TMR_W'(int_q));
                end
            end
            ST_INTEGRATE: begin
                if (tmr_expired) begin
                    nxt      = ST_ABG_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = GUARD_LOAD;
                    cnt_clr  = 1'b1;
                end
            end
            ST_ABG_LEAD: begin
                if (tmr_expired) begin
                    nxt = ST_SHIFT_REQ;
                end
            end
            ST_SHIFT_REQ: begin
                nxt = ST_SHIFT_WAIT;
            end
            ST_SHIFT_WAIT: begin
                if (vshift_done) begin
                    if (step_last) begin
                        nxt      = ST_ABG_TRAIL;
                        tmr_load = 1'b1;
                        tmr_val  = GUARD_LOAD;
                        cnt_clr  = 1'b1;
                    end else begin
                        nxt     = ST_SHIFT_REQ;
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_ABG_TRAIL: begin
                if (tmr_expired) begin
                    nxt = ST_LINE_REQ;
                end
            end
            ST_LINE_REQ: begin
                nxt = ST_LINE_WAIT;
            end
            ST_LINE_WAIT: begin
                if (line_done) begin
                    if (step_last) begin
                        nxt     = ST_DONE;
                        cnt_clr = 1'b1;
                    end else begin
                        nxt     = ST_LINE_REQ;
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                nxt = ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    // Moore outputs
    always_comb begin
        abg_high     = 1'b1;
        img_clear    = 1'b0;
        vshift_start = 1'b0;
        line_start   = 1'b0;
        line_active  = 1'b0;
        frame_done   = 1'b0;
        unique case (state)
            ST_IDLE, ST_INTEGRATE: ;
            ST_OBTURATE:   img_clear = 1'b1;
            ST_ABG_LEAD,
            ST_ABG_TRAIL,
            ST_SHIFT_WAIT: abg_high = 1'b0;
            ST_SHIFT_REQ: begin
                abg_high     = 1'b0;
                vshift_start = 1'b1;
            end
            ST_LINE_REQ: begin
                line_start  = 1'b1;
                line_active = 1'b1;
            end
            ST_LINE_WAIT:  line_active = 1'b1;
            ST_DONE:       frame_done  = 1'b1;
            default: ;
        endcase
    end

    assign line_class = cls;

    // Cycles the gate has been low, saturating at the guard length
    int unsigned low_run;
    always_ff @(posedge clk) begin
        if (!rst_n || abg_high) begin
            low_run <= 0;
        end else if (low_run < GUARD_CYC) begin
            low_run <= low_run + 1;
        end
    end

    AST_ABG_LOW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        vshift_start |-> !abg_high); // R5
    AST_CLEAR_GATE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        img_clear |-> abg_high); // R2
    AST_LEAD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        vshift_start |-> low_run >= GUARD_CYC); // R4
    AST_CLASS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_active && !line_start) |-> $stable(line_class)); // R9
    AST_DONE_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(line_done)); // R10
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vshift_start, line_start, frame_done, img_clear})); // R7

endmodule

// File: tb/test_ccd_frame_seq.sv
module test_ccd_frame_seq;

    localparam int GUARD = 10;
    localparam int TOTAL = 1056;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_frame = 1'b0;
    logic [15:0] obt_len = '0;
    logic [23:0] int_len = '0;
    logic        vshift_done = 1'b0;
    logic        line_done = 1'b0;
    logic        abg_high, img_clear, vshift_start, line_start, line_active, frame_done;
    logic [1:0]  line_class;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_v_done = 0;
    int last_l_done = 0;
    bit fin = 1'b0;

    ccd_frame_seq #(.GUARD_CYC(GUARD)) i_ccd_frame_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_frame  (start_frame),
        .obt_len      (obt_len),
        .int_len      (int_len),
        .vshift_done  (vshift_done),
        .line_done    (line_done),
        .abg_high     (abg_high),
        .img_clear    (img_clear),
        .vshift_start (vshift_start),
        .line_start   (line_start),
        .line_active  (line_active),
        .line_class   (line_class),
        .frame_done   (frame_done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected class code for line n: 00 dummy, 01 dark, 10 isolation, 11 useful
    function automatic logic [1:0] exp_class(input int n);
        if (n < 1 || n >= 1055) return 2'b00;
        if (n < 13 || n >= 1043) return 2'b01;
        if (n < 16 || n >= 1040) return 2'b10;
        return 2'b11;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Vertical phase generator model
    bit v_pend = 0;
    int v_wait = 0;
    always @(negedge clk) begin
        vshift_done = 1'b0;
        if (v_pend) begin
            if (v_wait == 0) begin
                vshift_done = 1'b1;
                v_pend = 0;
                last_v_done = cyc;
            end else begin
                v_wait--;
            end
        end
        if (vshift_start) begin
            v_pend = 1;
            v_wait = int'($urandom % 3);
        end
    end

    // Horizontal readout model
    bit l_pend = 0;
    int l_wait = 0;
    always @(negedge clk) begin
        line_done = 1'b0;
        if (l_pend) begin
            if (l_wait == 0) begin
                line_done = 1'b1;
                l_pend = 0;
                last_l_done = cyc;
            end else begin
                l_wait--;
            end
        end
        if (line_start) begin
            l_pend = 1;
            l_wait = int'($urandom % 3);
        end
    end

    task automatic run_frame(input int obt, input int intg, input bit poke_lens, input bit poke_start);
        int n_img = 0;
        int n_pre = 0;
        int g = 0;
        int nv = 0;
        int nl = 0;
        int bad_gate = 0;
        int cls_err = 0;
        int stab_err = 0;
        int idle_bad = 0;
        bit seen_rise = 0;
        bit poked = 0;
        logic [1:0] cur_cls = 2'b00;
        int exp_int = (intg == 0) ? 1 : intg;

        @(negedge clk);
        obt_len = 16'(obt);
        int_len = 24'(intg);
        start_frame = 1'b1;
        @(negedge clk);
        start_frame = 1'b0;
        if (poke_lens) begin
            obt_len = 16'(obt + 23);
            int_len = 24'(intg + 41);
        end
        while (abg_high) begin
            if (img_clear) n_img++;
            else n_pre++;
            @(negedge clk);
        end
        check(n_img == obt, poke_lens ? "R12 obturation length" : "R2 obturation length", n_img, obt);
        check(n_pre == exp_int, poke_lens ? "R12 integration length" : "R3 integration length", n_pre, exp_int);
        while (!vshift_start) begin
            g++;
            @(negedge clk);
        end
        check(g == GUARD, "R4 lead guard", g, GUARD);
        while (!frame_done) begin
            if (poke_start) start_frame = 1'b0;
            if (vshift_start) begin
                nv++;
                if (abg_high) bad_gate++;
            end
            if (abg_high && nv > 0 && !seen_rise) begin
                seen_rise = 1;
                check(cyc == last_v_done + GUARD + 1, "R6 trail guard", cyc - last_v_done, GUARD + 1);
            end
            if (line_start) begin
                if (line_class != exp_class(nl)) begin
                    cls_err++;
                    if (cls_err < 4)
                        $display("FAIL R8 line %0d class actual=%0d expected=%0d", nl, line_class, exp_class(nl));
                end
                cur_cls = line_class;
                nl++;
                if (poke_start && nl == 300 && !poked) begin
                    start_frame = 1'b1;
                    poked = 1;
                end
            end else if (line_active && line_class != cur_cls) begin
                stab_err++;
            end
            @(negedge clk);
        end
        check(nv == TOTAL, "R5 shift pulse count", nv, TOTAL);
        check(bad_gate == 0, "R5 gate low during shifts", bad_gate, 0);
        check(nl == TOTAL, "R7 line pulse count", nl, TOTAL);
        check(cls_err == 0, "R8 class errors", cls_err, 0);
        check(stab_err == 0, "R9 class changes within line", stab_err, 0);
        check(cyc == last_l_done + 1, "R10 done latency", cyc - last_l_done, 1);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (!abg_high || img_clear || vshift_start || line_start || line_active || frame_done)
                idle_bad++;
        end
        check(idle_bad == 0, poke_start ? "R11 start ignored" : "R10 idle after done", idle_bad, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        check(abg_high && !img_clear && !vshift_start && !line_start && !line_active && !frame_done && line_class == 2'b00,
              "R1 state in reset", int'(abg_high), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(abg_high && !img_clear && !vshift_start && !line_start && !line_active && !frame_done && line_class == 2'b00,
              "R1 idle after reset", int'({abg_high, img_clear, vshift_start, line_start, line_active, frame_done}), 32);

        run_frame(0, 1, 0, 0);   // no shutter, shortest integration
        run_frame(1, 5, 1, 0);   // one-cycle shutter, lengths changed after start
        run_frame(37, 20, 0, 1); // start request during readout
        run_frame(3, 0, 0, 0);   // zero integration treated as one
        for (int f = 0; f < 3; f++) begin
            int o = ($urandom % 4 == 0) ? 0 : int'($urandom % 60) + 1;
            int t = int'($urandom % 80) + 1;
            run_frame(o, t, 0, 0);
        end

        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule